// File: doc/BRIEF.md
# Fixed-Width Signed Array Multiplier

This block multiplies two N-bit two's-complement operands with a Baugh-Wooley partial-product array. Each cross term between one operand's sign bit and the other operand's magnitude bits is formed as an inverted AND. Two constant ones make up for the inversions, so the array only ever adds and never subtracts. The block reduces the array without a clock using carry-save rows of full adders, then resolves it with a ripple carry-propagate adder. The product is captured in one output register.

A parameter W sets how many columns below the upper half of the array are built. The block forms only the columns whose weight is 2^(N-W) or higher; the bits below that are never generated.

- With W = N the block is an exact multiplier with a 2N-bit result.
- With W < N the result is N bits wide and approximates product bits [2N-1:N].
- An optional fixed bias of 2^(N-1) can be added to offset the dropped columns, or switched off to give plain truncation.

A strobe marks each input pair. The valid flag and the product appear one clock later.

Top module: `bw_fixed_mult`

## Requirements
- R1: While reset is asserted and right after it, out_valid is 0 and prod_out is all zeros.
- R2: out_valid equals the value in_valid had at the previous rising clock edge, so the latency is exactly one cycle.
- R3: prod_out changes only after an edge at which in_valid was 1. It holds its value through cycles where in_valid is 0, even if x_in and y_in change.
- R4: With W = N, prod_out is 2N bits wide and equals the two's-complement product of x_in and y_in exactly. Each operand's top bit has weight -2^(N-1).
- R5: The most-negative operand squared gives 2^(2N-2) in full mode. At N=4 the truncated results are fixed values: 3 with W=0 and no bias, and 4 with W=2 and bias on.
- R6: With W < N and the bias off, let P be the exact product modulo 2^(2N). The array drops only columns c < N-W. A dropped column c < N-1 holds at most c+1 one-bits, and column N-1 holds at most N. With Dmax the largest weighted sum of those bits, prod_out modulo 2^N lies between floor((P-Dmax)/2^N) and floor(P/2^N).
- R7: With W < N and the bias on, 2^(N-1) is added to the kept sum. prod_out then lies between floor((P-Dmax+2^(N-1))/2^N) and floor((P+2^(N-1))/2^N), modulo 2^N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks x_in and y_in as an operand pair to multiply |
| x_in | input | N | Multiplicand, two's complement |
| y_in | input | N | Multiplier, two's complement |
| prod_out | output | 2N when W = N, else N | Registered product |
| out_valid | output | 1 | Set for one cycle for each accepted pair |

## Verification
A wrong cell in the array or in the adder chain shows up in the first product whose operand bits reach that cell. The error appears one cycle after the pair is presented. In full mode it is an exact mismatch. In truncated mode it pushes the result outside the error window that the dropped columns allow. Exhaustive sweeps at N=4 and random pairs at N=8 make sure every cross term and every carry path is exercised. A register that loads when it should hold shows at the ports in the first idle cycle after its inputs change.

// File: rtl/bw_mult_pkg.sv
package bw_mult_pkg;

   // Largest count of one-bits that can sit in an array column c below the upper half
   function automatic int col_drop_count(int n, int c);
      if (c < n - 1) return c + 1;
      return n;
   endfunction

   // Largest weighted value of all bits in the columns below low_col
   function automatic longint drop_max(int n, int low_col);
      longint acc;
      acc = 0;
      for (int c = 0; c < low_col; c++) acc += longint'(col_drop_count(n, c)) << c;
      return acc;
   endfunction

   // Worst downward error of the truncated result, in output LSBs
   function automatic int err_floor(int n, int low_col);
      return int'((drop_max(n, low_col) + (longint'(1) << n) - 1) >>> n);
   endfunction

endpackage

// File: rtl/bw_fa.sv
module bw_fa (
   input  logic a,
   input  logic b,
   input  logic ci,
   output logic s,
   output logic co
);
   assign s  = a ^ b ^ ci;
   assign co = (a & b) | (ci & (a ^ b));
endmodule

// File: rtl/bw_ha.sv
module bw_ha (
   input  logic a,
   input  logic b,
   output logic s,
   output logic co
);
   assign s  = a ^ b;
   assign co = a & b;
endmodule

// File: rtl/bw_pp_array.sv
// Partial-product rows, with the columns below LOW_COL never formed.
// Row i holds x[i]*y[j] at column i+j. Sign-by-magnitude terms are inverted.
// The last row holds the correction constants and the optional bias.
module bw_pp_array #(
   parameter int N       = 8,
   parameter int LOW_COL = 0,
   parameter bit BIAS_ON = 1'b0
) (
   input  logic [N-1:0]          x,
   input  logic [N-1:0]          y,
   output logic [N:0][2*N-1:0]   rows
);
   localparam int PW = 2 * N;
   localparam logic [PW-1:0] K_ONE  = 1;
   localparam logic [PW-1:0] K_CORR = (K_ONE << N) | (K_ONE << (PW - 1));
   localparam logic [PW-1:0] K_BIAS = BIAS_ON ? (K_ONE << (N - 1)) : '0;

   genvar i, c;
   generate
      for (i = 0; i < N; i++) begin : g_row
         for (c = 0; c < PW; c++) begin : g_col
            localparam int J = c - i;
            if (J >= 0 && J < N && c >= LOW_COL) begin : g_term
               if ((i == N - 1) != (J == N - 1)) begin : g_inv
                  assign rows[i][c] = ~(x[i] & y[J]);
               end else begin : g_pos
                  assign rows[i][c] = x[i] & y[J];
               end
            end else begin : g_zero
               assign rows[i][c] = 1'b0;
            end
         end
      end
   endgenerate

   assign rows[N] = K_CORR | K_BIAS;
endmodule

// File: rtl/bw_csa_row.sv
// One carry-save level: three rows in, a sum row and a carry row out.
module bw_csa_row #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic [WIDTH-1:0] c,
   output logic [WIDTH-1:0] sum,
   output logic [WIDTH-1:0] carry
);
   assign carry[0] = 1'b0;

   genvar k;
   generate
      for (k = 0; k < WIDTH - 1; k++) begin : g_fa
         bw_fa fa_i (
            .a (a[k]),
            .b (b[k]),
            .ci(c[k]),
            .s (sum[k]),
            .co(carry[k+1])
         );
      end
   endgenerate

   // the top column's carry would leave the result width
   assign sum[WIDTH-1] = a[WIDTH-1] ^ b[WIDTH-1] ^ c[WIDTH-1];
endmodule

// File: rtl/bw_cpa.sv
// Ripple carry-propagate adder that returns bits [WIDTH-1:OUT_LO].
// Columns below OUT_LO build only their carry.
module bw_cpa #(
   parameter int WIDTH  = 16,
   parameter int OUT_LO = 0
) (
   input  logic [WIDTH-1:0]        a,
   input  logic [WIDTH-1:0]        b,
   output logic [WIDTH-1:OUT_LO]   sum
);
   logic [WIDTH-1:1] cy;

   genvar k;
   generate
      if (OUT_LO == 0) begin : g_b0_full
         bw_ha ha_i (
            .a (a[0]),
            .b (b[0]),
            .s (sum[0]),
            .co(cy[1])
         );
      end else begin : g_b0_carry
         assign cy[1] = a[0] & b[0];
      end

      for (k = 1; k < WIDTH - 1; k++) begin : g_mid
         if (k >= OUT_LO) begin : g_full
            bw_fa fa_i (
               .a (a[k]),
               .b (b[k]),
               .ci(cy[k]),
               .s (sum[k]),
               .co(cy[k+1])
            );
         end else begin : g_carry
            assign cy[k+1] = (a[k] & b[k]) | (cy[k] & (a[k] ^ b[k]));
         end
      end
   endgenerate

   assign sum[WIDTH-1] = a[WIDTH-1] ^ b[WIDTH-1] ^ cy[WIDTH-1];
endmodule

// File: rtl/bw_fixed_mult.sv
module bw_fixed_mult #(
   parameter int N       = 8,
   parameter int W       = 8,
   parameter bit BIAS_EN = 1'b1,
   localparam int OUT_W  = (W == N) ? 2 * N : N
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [N-1:0]      x_in,
   input  logic [N-1:0]      y_in,
   output logic [OUT_W-1:0]  prod_out,
   output logic              out_valid
);
   localparam bit FULL    = (W == N);
   localparam int SUM_W   = 2 * N;
   localparam int LOW_COL = N - W;
   localparam bit BIAS_ON = BIAS_EN && !FULL;
   localparam int OUT_LO  = FULL ? 0 : N;

   generate
      if (N < 2) begin : g_bad_n
         $error("bw_fixed_mult: N must be at least 2");
      end
      if (W < 0 || W > N) begin : g_bad_w
         $error("bw_fixed_mult: W must lie in 0..N");
      end
   endgenerate

   logic [N:0][SUM_W-1:0]   pp_rows;
   logic [N-2:0][SUM_W-1:0] s_lvl;
   logic [N-2:0][SUM_W-1:0] c_lvl;
   logic [OUT_W-1:0]        sum_w;

   bw_pp_array #(
      .N      (N),
      .LOW_COL(LOW_COL),
      .BIAS_ON(BIAS_ON)
   ) pp_i (
      .x   (x_in),
      .y   (y_in),
      .rows(pp_rows)
   );

   // linear carry-save chain: rows 0..N folded in N-1 levels
   genvar k;
   generate
      for (k = 0; k < N - 1; k++) begin : g_lvl
         if (k == 0) begin : g_first
            bw_csa_row #(.WIDTH(SUM_W)) csa_i (
               .a    (pp_rows[0]),
               .b    (pp_rows[1]),
               .c    (pp_rows[2]),
               .sum  (s_lvl[0]),
               .carry(c_lvl[0])
            );
         end else begin : g_next
            bw_csa_row #(.WIDTH(SUM_W)) csa_i (
               .a    (s_lvl[k-1]),
               .b    (c_lvl[k-1]),
               .c    (pp_rows[k+2]),
               .sum  (s_lvl[k]),
               .carry(c_lvl[k])
            );
         end
      end
   endgenerate

   bw_cpa #(
      .WIDTH (SUM_W),
      .OUT_LO(OUT_LO)
   ) cpa_i (
      .a  (s_lvl[N-2]),
      .b  (c_lvl[N-2]),
      .sum(sum_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prod_out  <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) prod_out <= sum_w;
      end
   end
endmodule

// File: rtl/bw_mult_chk.sv
module bw_mult_chk #(
   parameter int N       = 8,
   parameter int W       = 8,
   parameter bit BIAS_EN = 1'b1,
   localparam int OUT_W  = (W == N) ? 2 * N : N
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [N-1:0]      x_in,
   input logic [N-1:0]      y_in,
   input logic [OUT_W-1:0]  prod_out,
   input logic              out_valid
);
   import bw_mult_pkg::*;

   logic signed [2*N-1:0] ref_p;
   logic signed [2*N-1:0] ref_q;

   assign ref_p = $signed(x_in) * $signed(y_in);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ref_q <= '0;
      else if (in_valid) ref_q <= ref_p;
   end

   p_valid_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_valid_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(prod_out));

   generate
      if (W == N) begin : g_full
         p_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (prod_out == ref_q));
      end else begin : g_trunc
         localparam int EMAX = err_floor(N, N - W);
         localparam int EUP  = BIAS_EN ? 1 : 0;
         logic signed [N-1:0] diff;
         assign diff = prod_out - ref_q[2*N-1:N];
         // R6 and R7: error of the truncated result stays inside its window
         p_err_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (int'(diff) >= -EMAX && int'(diff) <= EUP));
      end
   endgenerate
endmodule

bind bw_fixed_mult bw_mult_chk #(
   .N      (N),
   .W      (W),
   .BIAS_EN(BIAS_EN)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .x_in     (x_in),
   .y_in     (y_in),
   .prod_out (prod_out),
   .out_valid(out_valid)
);

// File: tb/bw_fixed_mult_tb_top.sv
`timescale 1ns/1ps
module bw_fixed_mult_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic v = 1'b0;
   logic [3:0] x4 = '0, y4 = '0;
   logic [7:0] x8 = '0, y8 = '0;

   logic [15:0] p_f8;
   logic [7:0]  p_t8, p_f4;
   logic [3:0]  p_z4, p_b4;
   logic        ov_f8, ov_t8, ov_f4, ov_z4, ov_b4;

   int n_checks = 0;
   int n_errs   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   bw_fixed_mult #(.N(8), .W(8), .BIAS_EN(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(v), .x_in(x8), .y_in(y8),
      .prod_out(p_f8), .out_valid(ov_f8));
   bw_fixed_mult #(.N(8), .W(3), .BIAS_EN(1'b1)) dut_t8_i (
      .clk(clk), .rst_n(rst_n), .in_valid(v), .x_in(x8), .y_in(y8),
      .prod_out(p_t8), .out_valid(ov_t8));
   bw_fixed_mult #(.N(4), .W(4), .BIAS_EN(1'b0)) dut_f4_i (
      .clk(clk), .rst_n(rst_n), .in_valid(v), .x_in(x4), .y_in(y4),
      .prod_out(p_f4), .out_valid(ov_f4));
   bw_fixed_mult #(.N(4), .W(0), .BIAS_EN(1'b0)) dut_z4_i (
      .clk(clk), .rst_n(rst_n), .in_valid(v), .x_in(x4), .y_in(y4),
      .prod_out(p_z4), .out_valid(ov_z4));
   bw_fixed_mult #(.N(4), .W(2), .BIAS_EN(1'b1)) dut_b4_i (
      .clk(clk), .rst_n(rst_n), .in_valid(v), .x_in(x4), .y_in(y4),
      .prod_out(p_b4), .out_valid(ov_b4));

   task automatic chk(bit ok, string req, longint act, longint exp);
      n_checks++;
      if (!ok) begin
         n_errs++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // worst weighted sum of the bits in columns below low (from R6)
   function automatic longint tb_dmax(int n, int low);
      longint s = 0;
      for (int c = 0; c < low; c++) s += longint'((c < n - 1) ? c + 1 : n) << c;
      return s;
   endfunction

   function automatic longint prod_mod(int n, longint a, longint b);
      return (a * b) & ((longint'(1) << (2 * n)) - 1);
   endfunction

   // R6/R7 window check
   function automatic bit win_ok(int n, int w, bit bias, longint pm, longint act);
      longint k  = longint'(1) << (2 * n);
      longint bb = (bias && w < n) ? (longint'(1) << (n - 1)) : 0;
      longint d  = tb_dmax(n, n - w);
      longint lo = (pm + k - d + bb) >> n;
      longint hi = (pm + k + bb) >> n;
      longint m  = (longint'(1) << n) - 1;
      for (longint t = lo; t <= hi; t++) if ((t & m) == act) return 1'b1;
      return 1'b0;
   endfunction

   task automatic run_vec(bit vld, logic [3:0] a4, logic [3:0] b4, logic [7:0] a8, logic [7:0] b8);
      logic [15:0] h_f8 = p_f8;
      logic [7:0]  h_t8 = p_t8, h_f4 = p_f4;
      logic [3:0]  h_z4 = p_z4, h_b4 = p_b4;
      longint pm4, pm8;
      @(negedge clk);
      v = vld; x4 = a4; y4 = b4; x8 = a8; y8 = b8;
      @(negedge clk);
      if (vld) begin
         pm4 = prod_mod(4, longint'($signed(a4)), longint'($signed(b4)));
         pm8 = prod_mod(8, longint'($signed(a8)), longint'($signed(b8)));
         chk(ov_f8 && ov_t8 && ov_f4 && ov_z4 && ov_b4, "R2 valid after strobe", longint'(ov_f8), 1);
         chk(p_f8 == pm8, "R4 full N=8", p_f8, pm8);
         chk(p_f4 == pm4, "R4 full N=4", p_f4, pm4);
         chk(win_ok(4, 0, 1'b0, pm4, p_z4), "R6 truncation W=0", p_z4, pm4 >> 4);
         chk(win_ok(8, 3, 1'b1, pm8, p_t8), "R7 bias W=3 N=8", p_t8, pm8 >> 8);
         chk(win_ok(4, 2, 1'b1, pm4, p_b4), "R7 bias W=2 N=4", p_b4, pm4 >> 4);
      end else begin
         chk(!(ov_f8 || ov_t8 || ov_f4 || ov_z4 || ov_b4), "R2 idle valid low", longint'(ov_f8), 0);
         chk(p_f8 == h_f8 && p_f4 == h_f4, "R3 full hold", p_f8, h_f8);
         chk(p_t8 == h_t8 && p_z4 == h_z4 && p_b4 == h_b4, "R3 truncated hold", p_t8, h_t8);
      end
      v = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd20771));
      repeat (3) @(negedge clk);
      chk(!(ov_f8 || ov_t8 || ov_f4 || ov_z4 || ov_b4), "R1 valid in reset", longint'(ov_f8), 0);
      chk(p_f8 == 0 && p_t8 == 0 && p_f4 == 0 && p_z4 == 0 && p_b4 == 0, "R1 product in reset", p_f8, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!ov_f8 && p_f8 == 0, "R1 after release", p_f8, 0);

      // directed corners
      run_vec(1'b1, 4'h8, 4'h8, 8'h80, 8'h80);
      chk(p_f4 == 8'd64, "R5 N=4 most-negative squared", p_f4, 64);
      chk(p_f8 == 16'd16384, "R5 N=8 most-negative squared", p_f8, 16384);
      chk(p_z4 == 4'd3, "R5 W=0 corner", p_z4, 3);
      chk(p_b4 == 4'd4, "R5 W=2 bias corner", p_b4, 4);
      run_vec(1'b0, 4'h7, 4'h3, 8'h11, 8'h22);
      run_vec(1'b1, 4'h8, 4'h7, 8'h80, 8'h7f);
      run_vec(1'b1, 4'h7, 4'h7, 8'h7f, 8'h7f);
      run_vec(1'b1, 4'hf, 4'hf, 8'hff, 8'hff);
      run_vec(1'b1, 4'h0, 4'h9, 8'h00, 8'hc3);

      // exhaustive N=4 with random N=8 alongside
      for (int a = 0; a < 16; a++) begin
         for (int b = 0; b < 16; b++) begin
            run_vec(1'b1, 4'(a), 4'(b), 8'($urandom), 8'($urandom));
            if (b == 7) run_vec(1'b0, 4'($urandom), 4'($urandom), 8'($urandom), 8'($urandom));
         end
      end

      // random mix of strobed and idle cycles
      for (int i = 0; i < 1500; i++) begin
         run_vec(($urandom % 5) != 0, 4'($urandom), 4'($urandom), 8'($urandom), 8'($urandom));
      end

      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_errs++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
         $finish;
      end
   end

endmodule